// File: doc/BRIEF.md
# SD Card Data FIFO Engine

This block sits between a host register interface and the byte-wide data stream of a memory card. On the host side it offers a 32-bit word FIFO, reached through a window of aliased word addresses, together with a small set of control and status registers. On the card side it has one byte handshake for each direction. A byte counter, loaded by the host, sets how many bytes the current transfer moves. A direction bit selects whether bytes flow from the card into the FIFO or from the FIFO out to the card.

When data moves from the card to the host, incoming bytes are packed little-endian into 32-bit words and pushed into the FIFO. If the count runs out partway through a word, the partial word is pushed with its upper lanes zeroed. When data moves from the host to the card, words written by the host are popped and sent one byte at a time, least significant byte first. Sending stops as soon as the count reaches zero, even in the middle of a word.

The host can read back the remaining byte count and the same count rounded up to whole words. Two registered flags report the FIFO occupancy. They are also visible in a status register.

Top module: `sdfifo_xfer`

## Requirements
- R1: After reset the byte count is zero, the FIFO is empty, `rx_avail` is 0, `tx_space` is 1, `card_rx_ready` is 0 and `card_tx_valid` is 0.
- R2: When the direction bit is 1, received byte number k of a transfer lands in byte lane k mod 4 (bits 8*(k mod 4)+7 down to 8*(k mod 4)) of FIFO word k/4. A word is pushed once its four lanes are filled.
- R3: Each byte accepted on either card handshake lowers the remaining count by one. Nothing else changes the count except a host write to the COUNT register at offset 0x04, which also reads back the count.
- R4: When the count reaches zero after one to three bytes of a word have been received, that word is pushed, with its unfilled upper lanes reading as zero.
- R5: In the card-to-host direction, `card_rx_ready` stays low while the FIFO holds DEPTH words. It rises again once the host frees a word, and the transfer then continues from the next byte.
- R6: When the direction bit is 0, each FIFO word is popped and sent on `card_tx_data` least significant byte first. `card_tx_valid` holds its byte until it is accepted. The lanes left over when the count reaches zero are discarded, and `card_tx_valid` stays low while the count is zero.
- R7: The WORDS register at offset 0x08 reads as (remaining count + 3) >> 2.
- R8: Every word offset from 0x80 to 0xBC reaches the same FIFO push/pop port.
- R9: A FIFO window read returns zero and changes no state when the FIFO is empty or the direction bit is 0. Otherwise it returns the oldest word and removes it.
- R10: A FIFO window write is ignored when the count is zero or the direction bit is 1. Otherwise it pushes the written word.
- R11: Bit 0 of the CTRL register at offset 0x00 is the direction bit, where 1 means card to host. Writing CTRL or COUNT discards any partially packed or partially sent word.
- R12: `rx_avail` is 1 whenever the FIFO holds at least one word, and `tx_space` is 1 whenever it holds fewer than DEPTH words. Both follow every push and pop, and both read back in the STATUS register at offset 0x0C, `rx_avail` in bit 0 and `tx_space` in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_rd_en | input | 1 | Host register read strobe |
| reg_addr | input | ADDR_W | Host byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid in the cycle of `reg_rd_en` |
| card_rx_valid | input | 1 | Card offers a received byte |
| card_rx_data | input | 8 | Received byte |
| card_rx_ready | output | 1 | Engine accepts the received byte |
| card_tx_valid | output | 1 | Engine offers a byte to send |
| card_tx_data | output | 8 | Byte to send |
| card_tx_ready | input | 1 | Card accepts the byte |
| rx_avail | output | 1 | FIFO holds at least one word |
| tx_space | output | 1 | FIFO has room for at least one word |

## Verification
The card-to-host path is swept over every transfer length from 1 to 24 bytes, plus the full-FIFO length. The card stalls in a pattern that changes with each length, so every lane position for the final partial word is covered, and lane misplacement can be told apart from a lost tail word. A longer transfer overruns the FIFO to show the stall and its clean resume. A flush in mid-word shows that stale lanes are dropped. The host-to-card path is swept over the same lengths to separate a correct early stop from a stray extra byte or an extra pop. Directed reads and writes against an empty FIFO, a zero count and the wrong direction show that ignored accesses leave the occupancy untouched.

// File: rtl/sdfifo_pkg.sv
package sdfifo_pkg;

    typedef logic [31:0] word_t;
    typedef logic [7:0]  byte_t;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_COUNT = 8'h04;
    localparam logic [7:0] OFS_WORDS = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;

    // FIFO window: 0x80 .. 0xBF, every word aliases one port
    function automatic logic in_window(input logic [7:0] a);
        return a[7:6] == 2'b10;
    endfunction

endpackage

// File: rtl/sdfifo_wordq.sv
module sdfifo_wordq #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [WIDTH-1:0]                push_data,
    input  logic                            pop,
    output logic [WIDTH-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]      occ,
    output logic                            not_empty,
    output logic                            not_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [OW-1:0] occ;
        logic          ne;
        logic          nf;
    } q_st_t;

    q_st_t st_q, st_d;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = bump(st_q.wp);
        if (pop)  st_d.rp = bump(st_q.rp);
        st_d.occ = st_q.occ + OW'(push) - OW'(pop);
        st_d.ne  = st_d.occ != '0;
        st_d.nf  = st_d.occ != OW'(DEPTH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wp  <= '0;
            st_q.rp  <= '0;
            st_q.occ <= '0;
            st_q.ne  <= 1'b0;
            st_q.nf  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= push_data;
    end

    assign head      = mem[st_q.rp];
    assign occ       = st_q.occ;
    assign not_empty = st_q.ne;
    assign not_full  = st_q.nf;

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.occ != OW'(DEPTH)));
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.occ != '0));
    // R12
    flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty == (occ != '0)) && (not_full == (occ != OW'(DEPTH))));

endmodule

// File: rtl/sdfifo_packer.sv
module sdfifo_packer
    import sdfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  take,
    input  byte_t byte_in,
    input  logic  last,
    output logic  push,
    output word_t word
);
    typedef struct packed {
        word_t      acc;
        logic [1:0] lane;
    } pk_st_t;

    pk_st_t st_q, st_d;
    word_t  merged;

    always_comb begin
        merged = st_q.acc | (word_t'(byte_in) << {st_q.lane, 3'b000});
        push   = take && ((st_q.lane == 2'd3) || last);
        word   = merged;
        st_d   = st_q;
        if (clear) begin
            st_d.acc  = '0;
            st_d.lane = '0;
        end else if (take) begin
            if (push) begin
                st_d.acc  = '0;
                st_d.lane = '0;
            end else begin
                st_d.acc  = merged;
                st_d.lane = st_q.lane + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    partial_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.lane != 2'd3) |-> (word[31:24] == 8'h00));

endmodule

// File: rtl/sdfifo_unpacker.sv
module sdfifo_unpacker
    import sdfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  enable,
    input  logic  fifo_ne,
    input  word_t head,
    input  logic  sent,
    input  logic  last,
    output logic  pop,
    output logic  tx_valid,
    output byte_t tx_data
);
    typedef struct packed {
        word_t      shreg;
        logic [2:0] left;
    } up_st_t;

    up_st_t st_q, st_d;

    always_comb begin
        pop      = enable && (st_q.left == 3'd0) && fifo_ne && !clear;
        tx_valid = enable && (st_q.left != 3'd0);
        tx_data  = st_q.shreg[7:0];
        st_d     = st_q;
        if (clear) begin
            st_d.left = 3'd0;
        end else if (pop) begin
            st_d.shreg = head;
            st_d.left  = 3'd4;
        end else if (sent) begin
            st_d.shreg = st_q.shreg >> 8;
            st_d.left  = last ? 3'd0 : st_q.left - 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !sent && !clear) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/sdfifo_xfer.sv
module sdfifo_xfer
    import sdfifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              card_rx_valid,
    input  logic [7:0]        card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_data,
    input  logic              card_tx_ready,
    output logic              rx_avail,
    output logic              tx_space
);
    localparam int OW = $clog2(DEPTH+1);

    typedef struct packed {
        logic             dir;
        logic [CNT_W-1:0] cnt;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [7:0]  a8;
    logic        wr_ctrl, wr_count, wr_win, rd_win, clear;
    logic        rx_take, tx_take, last;
    logic        host_push, host_pop, pk_push, up_pop, up_valid;
    logic        f_ne, f_nf;
    logic [OW-1:0] f_occ;
    word_t       f_head, pk_word, f_wdata;
    byte_t       up_byte;
    logic [CNT_W:0] words_up;
    logic        unused_bits;

    assign a8 = 8'(reg_addr);
    assign unused_bits = ^{reg_wdata[31:CNT_W], reg_addr};

    always_comb begin
        wr_ctrl  = reg_wr_en && (a8 == OFS_CTRL);
        wr_count = reg_wr_en && (a8 == OFS_COUNT);
        wr_win   = reg_wr_en && in_window(a8);
        rd_win   = reg_rd_en && in_window(a8);
        clear    = wr_ctrl || wr_count;
        last     = st_q.cnt == CNT_W'(1);

        card_rx_ready = st_q.dir && (st_q.cnt != '0) && f_nf && !clear;
        rx_take       = card_rx_ready && card_rx_valid;
        tx_take       = up_valid && card_tx_ready;

        host_push = wr_win && !st_q.dir && (st_q.cnt != '0) && f_nf;
        host_pop  = rd_win && st_q.dir && f_ne;
        f_wdata   = st_q.dir ? pk_word : reg_wdata;

        st_d = st_q;
        if (wr_ctrl) st_d.dir = reg_wdata[0];
        if (wr_count)                st_d.cnt = reg_wdata[CNT_W-1:0];
        else if (rx_take || tx_take) st_d.cnt = st_q.cnt - CNT_W'(1);

        words_up = ({1'b0, st_q.cnt} + (CNT_W+1)'(3)) >> 2;

        reg_rdata = '0;
        if (reg_rd_en) begin
            if (in_window(a8)) begin
                reg_rdata = host_pop ? f_head : 32'h0;
            end else begin
                case (a8)
                    OFS_CTRL:  reg_rdata = {31'h0, st_q.dir};
                    OFS_COUNT: reg_rdata = 32'(st_q.cnt);
                    OFS_WORDS: reg_rdata = 32'(words_up);
                    OFS_STAT:  reg_rdata = {30'h0, f_nf, f_ne};
                    default:   reg_rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sdfifo_wordq #(.DEPTH(DEPTH), .WIDTH(32)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pk_push || host_push),
        .push_data (f_wdata),
        .pop       (host_pop || up_pop),
        .head      (f_head),
        .occ       (f_occ),
        .not_empty (f_ne),
        .not_full  (f_nf)
    );

    sdfifo_packer u_pk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .take    (rx_take),
        .byte_in (card_rx_data),
        .last    (last),
        .push    (pk_push),
        .word    (pk_word)
    );

    sdfifo_unpacker u_up (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .enable   (!st_q.dir && (st_q.cnt != '0) && !clear),
        .fifo_ne  (f_ne),
        .head     (f_head),
        .sent     (tx_take),
        .last     (last),
        .pop      (up_pop),
        .tx_valid (up_valid),
        .tx_data  (up_byte)
    );

    assign card_tx_valid = up_valid;
    assign card_tx_data  = up_byte;
    assign rx_avail      = f_ne;
    assign tx_space      = f_nf;

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_count && (rx_take || tx_take)) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_count && !rx_take && !tx_take) |=> $stable(st_q.cnt));
    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_space |-> !card_rx_ready);
    // R6
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> (!card_tx_valid && !card_rx_ready));
    // R10
    ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_win && (st_q.cnt == '0) && !host_pop) |=> $stable(f_occ));

endmodule

// File: tb/sdfifo_xfer_tb.sv
`timescale 1ns/1ps
module sdfifo_xfer_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready, card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;
    logic        rx_avail, tx_space;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdfifo_xfer #(.DEPTH(DEPTH), .CNT_W(16), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
        .card_rx_ready(card_rx_ready),
        .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
        .card_tx_ready(card_tx_ready),
        .rx_avail(rx_avail), .tx_space(tx_space)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int i, input int salt);
        return 8'(i * 29 + salt * 7 + 3);
    endfunction

    function automatic logic [31:0] rword(input int w, input int len, input int salt);
        logic [31:0] r = '0;
        for (int j = 0; j < 4; j++)
            if (4 * w + j < len) r[8*j +: 8] = bval(4 * w + j, salt);
        return r;
    endfunction

    function automatic logic [31:0] wword(input int w, input int salt);
        return 32'((w + 1) * 32'h1357_9BDF) ^ 32'(salt * 32'h0101_0101);
    endfunction

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic feed(input int first, input int last_x, input int max_cyc,
                        input int salt, output int next);
        int i = first;
        int c = 0;
        while (i < last_x && c < max_cyc) begin
            @(negedge clk);
            c++;
            card_rx_valid = ((c + salt) % 3) != 0;
            card_rx_data  = bval(i, salt);
            #2;
            if (card_rx_valid && card_rx_ready) i++;
        end
        @(negedge clk);
        card_rx_valid = 1'b0;
        next = i;
    endtask

    task automatic sink(input int total, input int salt, output int got);
        int c = 0;
        logic [31:0] ew;
        got = 0;
        while (got < total && c < 2000) begin
            @(negedge clk);
            c++;
            card_tx_ready = ((c + salt) % 4) != 0;
            #2;
            if (card_tx_valid && card_tx_ready) begin
                ew = wword(got / 4, salt);
                chk("R6 tx byte", 32'(card_tx_data), 32'(ew[8*(got%4) +: 8]));
                got++;
            end
        end
        @(negedge clk);
        card_tx_ready = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int got, n, lens[$];

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 rx_ready", 32'(card_rx_ready), 0);
        chk("R1 tx_valid", 32'(card_tx_valid), 0);
        chk("R1 rx_avail", 32'(rx_avail), 0);
        chk("R1 tx_space", 32'(tx_space), 1);
        rst_n = 1'b1;
        reg_read(8'h04, d); chk("R1 count", d, 0);
        reg_read(8'h0C, d); chk("R1 status", d, 2);

        // R3 / R7 count and word readback
        for (int k = 0; k < 12; k++) begin
            n = (k < 10) ? k : ((k == 10) ? 1000 : 65535);
            reg_write(8'h04, 32'(n));
            reg_read(8'h04, d); chk("R3 count readback", d, 32'(n));
            reg_read(8'h08, d); chk("R7 word count", d, 32'((n + 3) >> 2));
        end
        reg_write(8'h04, 0);

        // R2 R4 R8 card-to-host sweep
        for (int l = 1; l <= 24; l++) lens.push_back(l);
        lens.push_back(64);
        foreach (lens[li]) begin
            int len = lens[li];
            reg_write(8'h00, 1);
            reg_write(8'h04, 32'(len));
            feed(0, len, 1000, len, got);
            chk("R2 bytes accepted", 32'(got), 32'(len));
            reg_read(8'h04, d); chk("R3 count at end", d, 0);
            if (len == 64) begin
                chk("R12 rx_avail full", 32'(rx_avail), 1);
                chk("R12 tx_space full", 32'(tx_space), 0);
            end
            for (int w = 0; w < (len + 3) / 4; w++) begin
                reg_read(8'(8'h80 + 4 * ((w + len) % 16)), d);
                chk("R2 R4 R8 word", d, rword(w, len, len));
            end
            reg_read(8'h84, d); chk("R9 empty read", d, 0);
            reg_read(8'h0C, d); chk("R12 status drained", d, 2);
        end

        // R5 stall on full FIFO and resume
        reg_write(8'h00, 1);
        reg_write(8'h04, 70);
        feed(0, 70, 200, 5, got);
        chk("R5 stalled at full", 32'(got), 64);
        chk("R5 rx_ready low", 32'(card_rx_ready), 0);
        reg_read(8'h04, d); chk("R5 count left", d, 6);
        for (int w = 0; w < 16; w++) begin
            reg_read(8'hBC, d); chk("R5 word", d, rword(w, 70, 5));
        end
        feed(64, 70, 200, 5, got);
        chk("R5 resumed", 32'(got), 70);
        for (int w = 16; w < 18; w++) begin
            reg_read(8'hA0, d); chk("R5 R4 tail word", d, rword(w, 70, 5));
        end

        // R11 flush of a partial word
        reg_write(8'h00, 1);
        reg_write(8'h04, 10);
        feed(0, 3, 100, 100, got);
        reg_write(8'h04, 4);
        feed(0, 4, 100, 200, got);
        reg_read(8'h80, d); chk("R11 flushed word", d, rword(0, 4, 200));
        reg_read(8'h80, d); chk("R11 no stale word", d, 0);
        reg_read(8'h00, d); chk("R11 dir readback", d, 1);

        // R6 host-to-card sweep
        foreach (lens[li]) begin
            int len = lens[li];
            reg_write(8'h00, 0);
            reg_write(8'h04, 32'(len));
            for (int w = 0; w < (len + 3) / 4; w++)
                reg_write(8'(8'h80 + 4 * (w % 16)), wword(w, len));
            sink(len, len, got);
            chk("R6 bytes sent", 32'(got), 32'(len));
            card_tx_ready = 1'b1;
            repeat (6) begin
                @(negedge clk); #2;
                chk("R6 no extra byte", 32'(card_tx_valid), 0);
            end
            card_tx_ready = 1'b0;
            reg_read(8'h0C, d); chk("R6 R12 fifo empty", d, 2);
        end

        // R10 write ignored with zero count
        reg_write(8'h00, 0);
        reg_write(8'h04, 0);
        reg_write(8'h90, 32'h5A5A_5A5A);
        reg_read(8'h0C, d); chk("R10 ignored write", d, 2);
        // R10 write ignored in card-to-host direction
        reg_write(8'h00, 1);
        reg_write(8'h04, 4);
        reg_write(8'h90, 32'h1234_5678);
        reg_read(8'h0C, d); chk("R10 ignored in rx dir", d, 2);

        // R9 read in host-to-card direction returns zero, keeps data
        reg_write(8'h00, 0);
        reg_write(8'h04, 8);
        reg_write(8'h80, wword(0, 9));
        reg_write(8'h84, wword(1, 9));
        repeat (3) @(negedge clk);
        reg_read(8'h0C, d); chk("R12 one word held", d, 3);
        reg_read(8'h88, d); chk("R9 tx dir read zero", d, 0);
        reg_read(8'h0C, d); chk("R9 state unchanged", d, 3);
        sink(8, 9, got);
        chk("R9 R6 remaining bytes", 32'(got), 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule